// File: doc/BRIEF.md
# Paged Multi-Channel Register Bank

This block holds the configuration storage of a four-channel device behind one byte-wide, 8-bit-addressed access port. The port carries read and write requests such as a serial management slave would issue. One shared register set and four per-channel register sets sit in that single address space. A page register at address 0xFF decides which set an access reaches. That register can always be written, whatever its current contents. The page register can also turn writes into broadcasts that update the same address in every channel set at once.

The shared set reports the strapped bus address, a fixed version and identity byte and per-channel interrupt flags. It also provides two self-clearing reset commands: one restores every shared register to its default, the other emits a one-cycle reset pulse for bus-master logic. Requests use a valid/ready handshake. A write is complete when it is accepted. A read is answered with one response beat, which the consumer takes with `rsp_ready`. Only one response can be held. While that response waits unaccepted, `req_ready` is low, so a new request is accepted only once the previous read data has been taken or is being taken in the same cycle.

Top module: `prb_bank`

## Requirements
- R1: After reset, `rsp_valid` and both reset pulses are 0, and `req_ready` is 1. Shared address 0x01 reads 0xD1 (version 3'b110 in bits 7:5, identity 5'b10001 in bits 4:0). Address 0x04 reads 0x01, address 0x07 reads 0x05, and the page register at 0xFF reads 0x00.
- R2: A write to 0xFF always updates the page register, whatever its mode. A read of 0xFF always returns the page register.
- R3: While page bit 2 is 0, reads and writes to every other address reach the shared set.
- R4: While page bit 2 is 1, reads and writes reach the channel set numbered by page bits 1:0. For example, address 0x00 then returns that channel's byte.
- R5: While page bits 3 and 2 are both 1, a write stores its byte at that address in all four channel sets. A read returns the channel numbered by bits 1:0.
- R6: Writes to read-only locations leave them unchanged. Those locations are register 0x00, register 0x01 and bits 4:0 of register 0x05.
- R7: Writing 0x04 with bit 6 set returns every shared register, including the page register, to its default. `ctl_rst_pulse` is high for the cycle after that write. Bit 6 reads back 0.
- R8: Writing 0x04 with bit 5 set raises `mstr_rst_pulse` for exactly the cycle after the write. Bit 5 reads back 0. Bits 7 and 4:0 of 0x04 are ordinary read/write bits.
- R9: Register 0x00 returns the strap in bits 7:4 and 0 in bits 3:0. `dev_addr` equals 0x18 plus the strap.
- R10: Register 0x05 bit 4 reads 1. Bits 3:0 show the interrupt inputs in reverse order, so bit 3 shows channel 0 and bit 0 shows channel 3. Bits 7:5 are read/write.
- R11: Shared addresses with no register (0x03 and 0x08 to 0xFE) read 0 and ignore writes. Every channel byte resets to 0.
- R12: A read accepted on one clock edge gives `rsp_valid` high after that edge. `rsp_rdata` is held stable and `req_ready` is low while `rsp_valid` is high and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with `req_valid` |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 8 | Read data |
| strap | input | 4 | Address strap value |
| irq | input | 4 | Per-channel interrupt flags, bit n for channel n |
| dev_addr | output | 7 | Effective bus address |
| mstr_rst_pulse | output | 1 | One-cycle reset for bus-master logic |
| ctl_rst_pulse | output | 1 | One-cycle indication of a shared-set reset |

## Verification
The checker assumes that the strap and interrupt inputs stay steady between a read's acceptance and its response. It also assumes the consumer never drops a pending response. The bench changes strap and interrupt values only between operations and keeps `rsp_ready` high except during one directed stall. The properties tie an accepted page write to the page contents on the next cycle. They tie a reset command in shared mode to its pulse and to an all-default page. They also follow the response hold rules under back-pressure. Random traffic is biased toward the page register and the low shared addresses, so mode changes, broadcasts and read-only writes are frequent.

// File: rtl/prb_pkg.sv
package prb_pkg;
  parameter int NUM_CH  = 4;
  parameter int SEL_W   = $clog2(NUM_CH);
  parameter int ADDR_W  = 8;
  parameter int DATA_W  = 8;
  parameter int STRAP_W = 4;
  parameter int DEPTH   = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_STRAP = 8'h00;
  localparam logic [ADDR_W-1:0] A_IDENT = 8'h01;
  localparam logic [ADDR_W-1:0] A_SPR2  = 8'h02;
  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h04;
  localparam logic [ADDR_W-1:0] A_STAT  = 8'h05;
  localparam logic [ADDR_W-1:0] A_SPR6  = 8'h06;
  localparam logic [ADDR_W-1:0] A_SPR7  = 8'h07;
  localparam logic [ADDR_W-1:0] A_PAGE  = 8'hFF;

  localparam logic [DATA_W-1:0] IDENT_VAL = 8'hD1;
  localparam logic [DATA_W-1:0] CTRL_RST  = 8'h01;
  localparam logic [DATA_W-1:0] SPR7_RST  = 8'h05;
  localparam logic [6:0]        DEV_BASE  = 7'h18;

  localparam int CTRL_SRST_BIT = 6;
  localparam int CTRL_MRST_BIT = 5;

  typedef struct packed {
    logic [3:0]       rsvd;
    logic             bcast;
    logic             ch_en;
    logic [SEL_W-1:0] sel;
  } page_t;
endpackage

// File: rtl/prb_chan_store.sv
module prb_chan_store
  import prb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/prb_shared_regs.sv
module prb_shared_regs
  import prb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               pg_wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [STRAP_W-1:0] strap,
  input  logic [NUM_CH-1:0]  irq,
  output page_t              page,
  output logic [DATA_W-1:0]  rdata,
  output logic               mstr_rst_pulse,
  output logic               ctl_rst_pulse
);
  logic [DATA_W-1:0] r_spr2, r_spr6, r_spr7, r_ctrl;
  logic [2:0]        r_stat_hi;
  logic [NUM_CH-1:0] irq_rev;
  logic              srst_hit, mrst_hit;

  assign srst_hit = wr_en && (addr == A_CTRL) && wdata[CTRL_SRST_BIT];
  assign mrst_hit = wr_en && (addr == A_CTRL) && wdata[CTRL_MRST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n || srst_hit) begin
      r_spr2    <= '0;
      r_spr6    <= '0;
      r_spr7    <= SPR7_RST;
      r_ctrl    <= CTRL_RST;
      r_stat_hi <= '0;
      page      <= '0;
    end else begin
      if (pg_wr) page <= page_t'(wdata);
      if (wr_en) begin
        unique case (addr)
          A_SPR2: r_spr2 <= wdata;
          A_SPR6: r_spr6 <= wdata;
          A_SPR7: r_spr7 <= wdata;
          A_CTRL: r_ctrl <= {wdata[7], 2'b00, wdata[4:0]};
          A_STAT: r_stat_hi <= wdata[7:5];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mstr_rst_pulse <= 1'b0;
      ctl_rst_pulse  <= 1'b0;
    end else begin
      mstr_rst_pulse <= mrst_hit;
      ctl_rst_pulse  <= srst_hit;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_irq
    assign irq_rev[NUM_CH-1-g] = irq[g];
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_STRAP: rdata = {strap, {(DATA_W-STRAP_W){1'b0}}};
      A_IDENT: rdata = IDENT_VAL;
      A_SPR2:  rdata = r_spr2;
      A_CTRL:  rdata = r_ctrl;
      A_STAT:  rdata = {r_stat_hi, 1'b1, irq_rev};
      A_SPR6:  rdata = r_spr6;
      A_SPR7:  rdata = r_spr7;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/prb_bank.sv
module prb_bank
  import prb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [STRAP_W-1:0] strap,
  input  logic [NUM_CH-1:0]  irq,
  output logic [6:0]         dev_addr,
  output logic               mstr_rst_pulse,
  output logic               ctl_rst_pulse
);
  page_t             page;
  logic              acc, is_page, pg_wr, sh_wr;
  logic [NUM_CH-1:0] ch_we;
  logic [DATA_W-1:0] sh_rdata, rd_mux;
  logic [DATA_W-1:0] ch_rdata [NUM_CH];

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign is_page   = (req_addr == A_PAGE);
  assign pg_wr     = acc && req_write && is_page;
  assign sh_wr     = acc && req_write && !is_page && !page.ch_en;
  assign dev_addr  = DEV_BASE + {{(7-STRAP_W){1'b0}}, strap};

  prb_shared_regs u_shared (
    .clk(clk), .rst_n(rst_n), .wr_en(sh_wr), .pg_wr(pg_wr),
    .addr(req_addr), .wdata(req_wdata), .strap(strap), .irq(irq),
    .page(page), .rdata(sh_rdata),
    .mstr_rst_pulse(mstr_rst_pulse), .ctl_rst_pulse(ctl_rst_pulse)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_we[c] = acc && req_write && !is_page && page.ch_en &&
                      (page.bcast || (page.sel == SEL_W'(c)));
    prb_chan_store u_store (
      .clk(clk), .rst_n(rst_n), .we(ch_we[c]),
      .addr(req_addr), .wdata(req_wdata), .rdata(ch_rdata[c])
    );
  end

  always_comb begin
    if (is_page)          rd_mux = page;
    else if (page.ch_en)  rd_mux = ch_rdata[page.sel];
    else                  rd_mux = sh_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/prb_bank_chk.sv
module prb_bank_chk
  import prb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mstr_rst_pulse,
  input logic              ctl_rst_pulse,
  input page_t             page
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_page_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == A_PAGE) |=> (page == $past(req_wdata)));

  p_shared_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == A_CTRL && !page.ch_en && req_wdata[CTRL_SRST_BIT])
    |=> (page == '0 && ctl_rst_pulse));

  p_mstr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == A_CTRL && !page.ch_en && req_wdata[CTRL_MRST_BIT])
    |=> mstr_rst_pulse);

  p_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && req_write && req_addr == A_CTRL && !page.ch_en) |=> !mstr_rst_pulse);

  p_strap_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == A_STRAP && !page.ch_en) |=> (rsp_rdata[3:0] == 4'h0));

  p_rd_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind prb_bank prb_bank_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .mstr_rst_pulse(mstr_rst_pulse), .ctl_rst_pulse(ctl_rst_pulse), .page(page)
);

// File: tb/test_prb_bank.sv
module test_prb_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       req_ready, rsp_valid, mstr_rst_pulse, ctl_rst_pulse;
  logic [7:0] rsp_rdata;
  logic [3:0] strap = 4'h5, irq = 4'h0;
  logic [6:0] dev_addr;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [7:0] m_page, m2, m4, m6, m7;
  logic [2:0] m5hi;
  logic [7:0] m_ch [4][256];

  always #2 clk = ~clk;

  prb_bank i_prb_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .strap(strap), .irq(irq), .dev_addr(dev_addr),
    .mstr_rst_pulse(mstr_rst_pulse), .ctl_rst_pulse(ctl_rst_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic void shared_defaults();
    m_page = 8'h00; m2 = 8'h00; m4 = 8'h01; m6 = 8'h00; m7 = 8'h05; m5hi = 3'b000;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'hFF) return m_page;
    if (m_page[2]) return m_ch[m_page[1:0]][a];
    case (a)
      8'h00: return {strap, 4'h0};
      8'h01: return 8'hD1;
      8'h02: return m2;
      8'h04: return m4;
      8'h05: return {m5hi, 1'b1, irq[0], irq[1], irq[2], irq[3]};
      8'h06: return m6;
      8'h07: return m7;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'hFF) m_page = d;
    else if (m_page[2]) begin
      for (int c = 0; c < 4; c++)
        if (m_page[3] || m_page[1:0] == c[1:0]) m_ch[c][a] = d;
    end else begin
      case (a)
        8'h02: m2 = d;
        8'h04: if (d[6]) shared_defaults(); else m4 = {d[7], 2'b00, d[4:0]};
        8'h05: m5hi = d[7:5];
        8'h06: m6 = d;
        8'h07: m7 = d;
        default: ;
      endcase
    end
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    logic [7:0] e;
    e = exp_rd(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_rdata === e, tag, int'({rsp_valid, rsp_rdata}), int'({1'b1, e}));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, d;
    int unsigned seed;
    shared_defaults();
    for (int c = 0; c < 4; c++) for (int i = 0; i < 256; i++) m_ch[c][i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 handshake", int'({rsp_valid, req_ready}), 1);
    chk(mstr_rst_pulse === 1'b0 && ctl_rst_pulse === 1'b0, "R1 pulses", int'({mstr_rst_pulse, ctl_rst_pulse}), 0);
    rd(8'h01, "R1 ident");
    rd(8'h04, "R1 ctrl");
    rd(8'h07, "R1 spare7");
    rd(8'hFF, "R1 page");
    // R9 strap and device address
    chk(dev_addr === 7'h1D, "R9 dev_addr", int'(dev_addr), 'h1D);
    rd(8'h00, "R9 strap");
    strap = 4'hA;
    @(negedge clk);
    chk(dev_addr === 7'h22, "R9 dev_addr", int'(dev_addr), 'h22);
    // R11 unimplemented and channel reset value
    wr(8'h03, 8'h5A);
    rd(8'h03, "R11 hole");
    wr(8'h80, 8'hC3);
    rd(8'h80, "R11 hole");
    // R6 read-only
    wr(8'h01, 8'h00);
    rd(8'h01, "R6 ident");
    wr(8'h00, 8'hFF);
    rd(8'h00, "R6 strap");
    irq = 4'b0001;
    wr(8'h05, 8'hFF);
    rd(8'h05, "R10 stat");
    // R4 channel page
    wr(8'hFF, 8'h05);
    rd(8'h00, "R11 chan reset");
    wr(8'h00, 8'h3C);
    rd(8'h00, "R4 chan1");
    rd(8'hFF, "R2 page");
    wr(8'hFF, 8'h00);
    rd(8'h00, "R3 shared");
    // R5 broadcast
    wr(8'hFF, 8'h0E);
    wr(8'h10, 8'hA5);
    rd(8'h10, "R5 read sel2");
    wr(8'hFF, 8'h04);
    rd(8'h10, "R5 ch0");
    wr(8'hFF, 8'h07);
    rd(8'h10, "R5 ch3");
    rd(8'h00, "R4 ch3");
    // R8 master reset pulse
    wr(8'hFF, 8'h00);
    wr(8'h04, 8'hA3);
    chk(mstr_rst_pulse === 1'b1, "R8 pulse", int'(mstr_rst_pulse), 1);
    @(negedge clk);
    chk(mstr_rst_pulse === 1'b0, "R8 pulse end", int'(mstr_rst_pulse), 0);
    rd(8'h04, "R8 readback");
    // R7 shared reset
    wr(8'hFF, 8'h30);
    wr(8'h06, 8'h77);
    wr(8'h04, 8'h40);
    chk(ctl_rst_pulse === 1'b1, "R7 pulse", int'(ctl_rst_pulse), 1);
    rd(8'hFF, "R7 page");
    rd(8'h06, "R7 spare6");
    rd(8'h04, "R7 ctrl");
    // R12 back-pressure
    wr(8'h02, 8'h9C);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h02;
    @(negedge clk);
    req_addr = 8'h07;
    chk(rsp_valid === 1'b1 && rsp_rdata === 8'h9C, "R12 resp", int'(rsp_rdata), 'h9C);
    chk(req_ready === 1'b0, "R12 stall", int'(req_ready), 0);
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_rdata === 8'h9C, "R12 hold", int'(rsp_rdata), 'h9C);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R12 drain", int'(rsp_valid), 0);
    // random mix
    seed = 32'd1234;
    void'($urandom(seed));
    for (int it = 0; it < 3000; it++) begin
      if (it % 64 == 0) begin
        strap = 4'($urandom);
        irq = 4'($urandom);
      end
      case ($urandom % 8)
        0, 1: a = 8'hFF;
        2, 3, 4: a = 8'($urandom % 8);
        5: a = 8'h04;
        default: a = 8'($urandom);
      endcase
      d = 8'($urandom);
      if (a == 8'h04 && ($urandom % 16) != 0) d[6] = 1'b0;
      if ($urandom % 2) wr(a, d);
      else rd(a, "R3 R4 R5 random read");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule